// File: doc/BRIEF.md
# PHY Management Register Bridge

This block puts a single 32-bit command/status word in front of a two-wire PHY management bus (MDC clock, bidirectional MDIO data). Software writes the word once to start a transaction. The top bit of that write chooses the direction: a 1 requests a write of the low 16 bits into a PHY register, and a 0 requests a read. The same bit then reports completion. A finished write clears it, and a finished read sets it once the low 16 bits hold the value returned by the PHY.

Each transaction is a 64-bit frame. It has a run of preamble ones, a start code, an opcode, the PHY address fixed by a parameter, the 5-bit register address, a two-bit turnaround and 16 data bits. All fields go out most significant bit first. MDC runs only during a frame and is derived from the system clock by a divider parameter. The bridge changes MDIO on the falling edge of MDC and samples it on the rising edge. Software polls the flag. At the default divider a frame takes 512 system cycles, well inside the millisecond that software allows.

Top module: `mdio_reg_bridge`

## Requirements
- R1: After reset the register reads as all zeros, MDC is low and MDIO is not driven (`mdioOe` low).
- R2: The register reads as flag in bit 31, zeros in bits 30:21, register address in bits 20:16 and data in bits 15:0, at all times. The values written to bits 30:21 have no effect. The cycle after a command is accepted, the register shows the written flag, address and data.
- R3: A command with bit 31 = 1 sends 32 ones, start code 01, opcode 01, the PHY address, the register address, turnaround 10 and bits 15:0, with every bit driven. When the frame ends, bit 31 reads 0 and bits 15:0 are unchanged.
- R4: A command with bit 31 = 0 sends opcode 10 and releases MDIO (`mdioOe` low) from the first turnaround bit through the last data bit. The 16 data bits are sampled from `mdioIn`, MSB first, and placed in bits 15:0. Bit 31 then reads 1.
- R5: Each bit period holds MDC low for `MDC_HALF` system cycles and then high for `MDC_HALF` cycles. A frame has 64 bit periods. The flag changes on the clock edge that ends the 64th high phase, which is `128*MDC_HALF` cycles after the accepting edge.
- R6: During a frame, `mdioOut` changes only on the clock edge where MDC falls. It is therefore stable while MDC is high.
- R7: A register write that arrives while a frame is in progress is ignored. The register contents, the frame on the wire and the final result are unaffected, and no extra frame follows.
- R8: While no frame is in progress, MDC stays low and `mdioOe` stays low.
- R9: A new command is accepted on the first clock edge after the one that completed the previous frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Write strobe for the command/status register |
| regWrData | input | 32 | Word written to the register |
| regRdData | output | 32 | Current register contents (flag, address, data) |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Management data driven toward the PHY |
| mdioOe | output | 1 | Output enable for `mdioOut` |
| mdioIn | input | 1 | Management data received from the PHY |

## Verification
Five properties are checked on every cycle. The bus is quiet whenever no frame is running. `mdioOut` moves only when MDC falls. Every MDC high phase lasts exactly the divider count. The flag and address fields hold still for the whole of a frame. The flag flips exactly when a frame ends. The bench scenarios show what those properties cannot: the exact frame bit sequence and the output-enable pattern for both directions, data returned from a modelled PHY and written back through it, the total frame length, and the handling of a command that arrives while a frame is running.

// File: rtl/mdio_bridge_pkg.sv
`timescale 1ns/1ps
package mdio_bridge_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;   // command accepted this cycle
    logic rise;   // MDC rises at this edge: sample MDIO
    logic fall;   // MDC falls at this edge: advance MDIO
    logic last;   // current bit is the final bit of the frame
  } mdioStrb_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } mdcPhase_t;

  localparam int ADDR_BITS  = 5;
  localparam int DATA_BITS  = 16;
  localparam int HDR_BITS   = 2 + 2 + ADDR_BITS + ADDR_BITS;   // start, op, phy, reg
  localparam int BODY_BITS  = HDR_BITS + 2 + DATA_BITS;        // plus turnaround

  localparam logic [1:0] START_CODE = 2'b01;
  localparam logic [1:0] OP_WRITE   = 2'b01;
  localparam logic [1:0] OP_READ    = 2'b10;
  localparam logic [1:0] TA_WRITE   = 2'b10;
  localparam logic [1:0] TA_IDLE    = 2'b11;

endpackage

// File: rtl/mdio_ctrl.sv
`timescale 1ns/1ps
module mdio_ctrl
  import mdio_bridge_pkg::*;
#(
  parameter int MDC_HALF  = 4,
  parameter int FRAME_LEN = 64,
  localparam int IDX_W    = $clog2(FRAME_LEN)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  output logic             busy,
  output logic             mdc,
  output mdioStrb_t        strb,
  output logic [IDX_W-1:0] bitIdx
);

  localparam int DIV_W = (MDC_HALF > 1) ? $clog2(MDC_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(MDC_HALF - 1);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

  mdcPhase_t        phase;
  logic [DIV_W-1:0] divCnt;
  logic             halfDone;
  logic             mdcQ;

  always_comb begin
    halfDone  = (divCnt == DIV_LAST);
    strb.load = (phase == PH_IDLE) && startReq;
    strb.rise = (phase == PH_LOW)  && halfDone;
    strb.fall = (phase == PH_HIGH) && halfDone;
    strb.last = (bitIdx == IDX_LAST);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase  <= PH_IDLE;
      divCnt <= '0;
      bitIdx <= '0;
      mdcQ   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (strb.load) begin
            phase  <= PH_LOW;
            divCnt <= '0;
            bitIdx <= '0;
          end
        end
        PH_LOW: begin
          if (halfDone) begin
            phase  <= PH_HIGH;
            divCnt <= '0;
            mdcQ   <= 1'b1;
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        PH_HIGH: begin
          if (halfDone) begin
            divCnt <= '0;
            mdcQ   <= 1'b0;
            if (strb.last) begin
              phase <= PH_IDLE;
            end else begin
              phase  <= PH_LOW;
              bitIdx <= bitIdx + 1'b1;
            end
          end else begin
            divCnt <= divCnt + 1'b1;
          end
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign busy = (phase != PH_IDLE);
  assign mdc  = mdcQ;

endmodule

// File: rtl/mdio_datapath.sv
`timescale 1ns/1ps
module mdio_datapath
  import mdio_bridge_pkg::*;
#(
  parameter int PHY_ADDR  = 1,
  parameter int PRE_LEN   = 32,
  localparam int FRAME_LEN = PRE_LEN + BODY_BITS,
  localparam int IDX_W     = $clog2(FRAME_LEN)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mdioStrb_t            strb,
  input  logic [IDX_W-1:0]     bitIdx,
  input  logic                 cmdFlag,
  input  logic [ADDR_BITS-1:0] cmdAddr,
  input  logic [DATA_BITS-1:0] cmdData,
  input  logic                 mdioIn,
  output logic [31:0]          regRdData,
  output logic                 mdioOut,
  output logic                 mdioOe
);

  localparam int TA_START   = PRE_LEN + HDR_BITS;
  localparam int DATA_START = TA_START + 2;

  logic                 flagQ;
  logic [ADDR_BITS-1:0] addrQ;
  logic [DATA_BITS-1:0] dataQ;
  logic                 isReadQ;
  logic                 oeQ;
  logic [FRAME_LEN-1:0] frameSh;
  logic [FRAME_LEN-1:0] frameLoad;
  logic [DATA_BITS-1:0] capSh;
  logic                 nextReleased;
  logic                 inDataPhase;

  // Serial image of the whole frame, MSB leaves first
  always_comb begin
    frameLoad = { {PRE_LEN{1'b1}},
                  START_CODE,
                  cmdFlag ? OP_WRITE : OP_READ,
                  ADDR_BITS'(PHY_ADDR),
                  cmdAddr,
                  cmdFlag ? TA_WRITE : TA_IDLE,
                  cmdFlag ? cmdData  : {DATA_BITS{1'b1}} };
    nextReleased = isReadQ && ((int'(bitIdx) + 1) >= TA_START);
    inDataPhase  = int'(bitIdx) >= DATA_START;
  end

  // Command/status register
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ   <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
      isReadQ <= 1'b0;
    end else if (strb.load) begin
      flagQ   <= cmdFlag;
      addrQ   <= cmdAddr;
      dataQ   <= cmdData;
      isReadQ <= !cmdFlag;
    end else if (strb.fall && strb.last) begin
      flagQ <= isReadQ;
      if (isReadQ) begin
        dataQ <= capSh;
      end
    end
  end

  // Frame shifter and pin enable
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      frameSh <= '1;
      oeQ     <= 1'b0;
    end else if (strb.load) begin
      frameSh <= frameLoad;
      oeQ     <= 1'b1;
    end else if (strb.fall) begin
      if (strb.last) begin
        frameSh <= '1;
        oeQ     <= 1'b0;
      end else begin
        frameSh <= {frameSh[FRAME_LEN-2:0], 1'b1};
        oeQ     <= !nextReleased;
      end
    end
  end

  // Read data capture on MDC rising edges
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      capSh <= '0;
    end else if (strb.rise && isReadQ && inDataPhase) begin
      capSh <= {capSh[DATA_BITS-2:0], mdioIn};
    end
  end

  assign regRdData = {flagQ, 10'b0, addrQ, dataQ};
  assign mdioOut   = frameSh[FRAME_LEN-1];
  assign mdioOe    = oeQ;

endmodule

// File: rtl/mdio_reg_bridge.sv
`timescale 1ns/1ps
module mdio_reg_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PHY_ADDR = 1,
  parameter int MDC_HALF = 4,
  parameter int PRE_LEN  = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [31:0] regWrData,
  output logic [31:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);

  localparam int FRAME_LEN = PRE_LEN + BODY_BITS;
  localparam int IDX_W     = $clog2(FRAME_LEN);

  mdioStrb_t        strb;
  logic [IDX_W-1:0] bitIdx;
  logic             busy;
  logic             unusedRsvBits;

  assign unusedRsvBits = ^regWrData[30:21];

  mdio_ctrl #(
    .MDC_HALF (MDC_HALF),
    .FRAME_LEN(FRAME_LEN)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .startReq(regWrEn),
    .busy    (busy),
    .mdc     (mdc),
    .strb    (strb),
    .bitIdx  (bitIdx)
  );

  mdio_datapath #(
    .PHY_ADDR(PHY_ADDR),
    .PRE_LEN (PRE_LEN)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .cmdFlag  (regWrData[31]),
    .cmdAddr  (regWrData[20:16]),
    .cmdData  (regWrData[15:0]),
    .mdioIn   (mdioIn),
    .regRdData(regRdData),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe)
  );

endmodule

// File: rtl/mdio_bridge_chk.sv
`timescale 1ns/1ps
module mdio_bridge_chk #(
  parameter int MDC_HALF = 4
) (
  input logic       clk,
  input logic       rstN,
  input logic       busy,
  input logic       mdc,
  input logic       mdioOut,
  input logic       mdioOe,
  input logic       flag,
  input logic [4:0] regAddrField
);

  logic        mdcD;
  logic [15:0] runLen;

  // Length of the current MDC level, in cycles
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mdcD   <= 1'b0;
      runLen <= '0;
    end else begin
      mdcD <= mdc;
      if (mdc != mdcD) begin
        runLen <= 16'd1;
      end else if (runLen != 16'hFFFF) begin
        runLen <= runLen + 16'd1;
      end
    end
  end

  p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  p_out_on_fall_r6: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> $fell(mdc));

  p_high_phase_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(mdc) |-> (runLen == 16'(MDC_HALF)));

  p_cmd_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(flag) && $stable(regAddrField)));

  // Also covers R4: a read sets the flag at completion
  p_flag_flip_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (flag != $past(flag)));

endmodule

bind mdio_reg_bridge mdio_bridge_chk #(.MDC_HALF(MDC_HALF)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .busy        (busy),
  .mdc         (mdc),
  .mdioOut     (mdioOut),
  .mdioOe      (mdioOe),
  .flag        (regRdData[31]),
  .regAddrField(regRdData[20:16])
);

// File: tb/sim_mdio_reg_bridge.sv
`timescale 1ns/1ps
module sim_mdio_reg_bridge;

  localparam int          BH   = 4;
  localparam logic [4:0]  BPHY = 5'h13;
  localparam int          FRAME_CYC = 128 * BH;

  typedef struct {
    logic [63:0] bits;
    logic [63:0] oe;
    string       tag;
  } frame_t;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        mdc;
  logic        mdioOut;
  logic        mdioOe;
  logic        mdioIn;

  int nChk  = 0;
  int nFail = 0;
  int r6Bad = 0;
  int monCnt = 0;
  logic [63:0] obsBits = '0;
  logic [63:0] obsOe   = '0;
  logic [15:0] phyRegs [32];
  frame_t      expQ [$];

  always #4 clk = ~clk;

  mdio_reg_bridge #(
    .PHY_ADDR(int'(BPHY)),
    .MDC_HALF(BH),
    .PRE_LEN (32)
  ) u0 (
    .clk      (clk),
    .rstN     (rstN),
    .regWrEn  (regWrEn),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .mdc      (mdc),
    .mdioOut  (mdioOut),
    .mdioOe   (mdioOe),
    .mdioIn   (mdioIn)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nChk++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // Monitor: collects frames off the wire and compares with the queue
  initial begin
    frame_t f;
    forever begin
      @(posedge mdc);
      #1;
      obsBits = {obsBits[62:0], mdioOut};
      obsOe   = {obsOe[62:0], mdioOe};
      monCnt++;
      if (monCnt == 64) begin
        if (expQ.size() == 0) begin
          chk("R7", "unexpected frame on wire", obsBits, 64'h0);
        end else begin
          f = expQ.pop_front();
          chk(f.tag, "output-enable pattern", obsOe, f.oe);
          chk(f.tag, "driven frame bits", obsBits & f.oe, f.bits & f.oe);
        end
        if (obsBits[29:28] == 2'b01) begin
          phyRegs[obsBits[22:18]] = obsBits[15:0];
        end
        monCnt = 0;
      end
    end
  end

  // PHY model: answers reads, changes MDIO after MDC falls
  initial begin
    logic       phyRd;
    logic [4:0] phySel;
    phyRd  = 1'b0;
    phySel = '0;
    mdioIn = 1'b1;
    forever begin
      @(negedge mdc);
      if (monCnt < 47) begin
        phyRd  = 1'b0;
        mdioIn = 1'b1;
      end else if (monCnt == 47) begin
        phyRd  = ({obsBits[12], obsBits[11]} == 2'b10);
        phySel = obsBits[5:1];
        mdioIn = phyRd ? 1'b0 : 1'b1;
      end else if (phyRd && monCnt <= 63) begin
        mdioIn = phyRegs[phySel][63 - monCnt];
      end else begin
        mdioIn = 1'b1;
      end
    end
  end

  // R6 watcher: MDIO must hold while MDC stays high
  initial begin
    logic prevMdc;
    logic prevOut;
    prevMdc = 1'b0;
    prevOut = 1'b1;
    forever begin
      @(negedge clk);
      if (prevMdc && mdc && (mdioOut !== prevOut)) r6Bad++;
      prevMdc = mdc;
      prevOut = mdioOut;
    end
  end

  // Driver: issue one command, push the expected frame, wait for completion
  task automatic doCmd(input bit isWr, input logic [4:0] ra,
                       input logic [15:0] d, input string accTag);
    frame_t      f;
    logic [15:0] expData;
    int          e;
    expData = isWr ? d : phyRegs[ra];
    f.bits  = {32'hFFFF_FFFF, 2'b01, (isWr ? 2'b01 : 2'b10), BPHY, ra,
               (isWr ? 2'b10 : 2'b00), (isWr ? d : 16'h0000)};
    f.oe    = isWr ? {64{1'b1}} : {{46{1'b1}}, {18{1'b0}}};
    f.tag   = isWr ? "R3" : "R4";
    expQ.push_back(f);
    regWrData = {isWr, 10'h3FF, ra, d};
    regWrEn   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    regWrEn = 1'b0;
    chk(accTag, "register after accept", 64'(regRdData),
        64'({isWr, 10'h000, ra, d}));
    e = 0;
    do begin
      @(posedge clk);
      e++;
      @(negedge clk);
    end while ((regRdData[31] != !isWr) && (e < 5000));
    chk("R5", "cycles from accept to completion", 64'(e), 64'(FRAME_CYC));
    chk(isWr ? "R3" : "R4", "register at completion", 64'(regRdData),
        64'({!isWr, 10'h000, ra, (isWr ? d : expData)}));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChk++;
    nFail++;
    $display("FAIL R5 watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

  initial begin
    logic [31:0] snap;
    int          idleBad;
    for (int i = 0; i < 32; i++) phyRegs[i] = 16'h5A3C ^ (16'(i) * 16'h0101);
    rstN      = 1'b0;
    regWrEn   = 1'b0;
    regWrData = '0;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1", "register after reset", 64'(regRdData), 64'h0);
    chk("R1", "mdc after reset", 64'(mdc), 64'h0);
    chk("R1", "mdioOe after reset", 64'(mdioOe), 64'h0);

    // R3 write then R4 read back through the PHY model
    doCmd(1'b1, 5'd4, 16'h01E0, "R2");
    doCmd(1'b0, 5'd4, 16'h1234, "R2");
    // Read of registers never written, address extremes
    doCmd(1'b0, 5'd31, 16'h0000, "R2");
    doCmd(1'b0, 5'd0, 16'hFFFF, "R2");
    // Data extremes
    doCmd(1'b1, 5'd9, 16'hFFFF, "R2");
    doCmd(1'b1, 5'd10, 16'h0000, "R2");
    doCmd(1'b0, 5'd9, 16'h0000, "R2");
    doCmd(1'b0, 5'd10, 16'hFFFF, "R2");

    // R9 back-to-back: next command right after completion
    doCmd(1'b1, 5'd17, 16'hA5C3, "R2");
    doCmd(1'b0, 5'd17, 16'h0F0F, "R9");

    // R7 a write during a running frame is ignored
    fork
      doCmd(1'b1, 5'd22, 16'h3C96, "R2");
      begin
        repeat (100) @(negedge clk);
        snap      = regRdData;
        regWrData = {1'b0, 10'h000, 5'd3, 16'h7777};
        regWrEn   = 1'b1;
        @(negedge clk);
        regWrEn = 1'b0;
        chk("R7", "register after write while busy", 64'(regRdData), 64'(snap));
      end
    join
    doCmd(1'b0, 5'd22, 16'h0000, "R2");

    // R8 quiet bus while idle, and no stray frame (R7)
    idleBad = 0;
    repeat (300) begin
      @(negedge clk);
      if (mdc || mdioOe) idleBad++;
    end
    chk("R8", "idle cycles with MDC high or MDIO driven", 64'(idleBad), 64'h0);
    chk("R7", "frames still expected", 64'(expQ.size()), 64'h0);
    chk("R6", "MDIO changes while MDC high", 64'(r6Bad), 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nFail);
    $finish;
  end

endmodule